// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block sequences power-down for a small microcontroller core. When the core executes its sleep instruction, the block first decides whether the instruction really puts the device to sleep. If an enabled interrupt request was already pending, the instruction completes as a no-op. Otherwise the block clears the watchdog, records the power-down in the status bits and gates the core clock off.

While the device is asleep, three events can end it. A master reset produces a full core reset. A watchdog time-out or an enabled interrupt resumes execution without a reset. On that continuation path the block runs an oscillator start-up delay for crystal modes and skips it for RC mode. It then re-enables the clock and sends the core a one-cycle fetch command. That command tells the core either to continue in line or, if the global interrupt enable is set, to branch to the interrupt vector after the prefetched instruction. Inserting the dummy cycles for that branch is the core's job.

Two status bits let software tell what happened. `pd_o` reports whether the device actually slept. `to_o` reports whether a watchdog time-out caused the wake-up.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After power-on reset (`rst_ni` low), `clk_en_o`=1, `pd_o`=1, `to_o`=1, `fetch_o`=2'b00, `wdt_clr_o`=0 and `core_rst_o`=0.
- R2: While asleep, the device wakes when some source i has both `irq_flag_i[i]` and `irq_en_i[i]` set, or when `wdt_to_i` is high. This holds whatever `gie_i` is. A flag whose own enable bit is clear does not wake the device, even if another source's enable bit is set.
- R3: A wake-up caused by `wdt_to_i` clears `to_o` on the next clock edge. A wake-up caused by an interrupt leaves `to_o` at 1.
- R4: A sleep request (`sleep_i` high while running) is a no-op if an enabled flag was already pending in the previous cycle. In that case `wdt_clr_o` stays 0, `clk_en_o` stays 1 and `pd_o` is unchanged.
- R5: Otherwise, a sleep request raises `wdt_clr_o` in the same cycle. On the next edge it gives `pd_o`=0, `to_o`=1 and `clk_en_o`=0. A request that first appears in the same cycle as `sleep_i` counts as arriving during the sleep: the device fully sleeps and then wakes on the following edge.
- R6: `mclr_i` high on an edge, in any state, forces the running state. It also makes `core_rst_o`=1 for the following cycle and leaves `pd_o` and `to_o` unchanged. It takes priority over a sleep request in the same cycle.
- R7: In the first cycle that `clk_en_o` is back at 1 after a continuation wake-up, `fetch_o` is 2'b10 (branch to vector) if `gie_i`=1 and 2'b01 (resume in line) if `gie_i`=0. In every other cycle `fetch_o` is 2'b00, including after a master reset.
- R8: With `osc_rc_i`=0, `clk_en_o` returns 1+2**OST_BITS clock edges after the wake condition is first seen. With `osc_rc_i`=1 it returns after 1 edge. The start-up counter restarts from zero on every entry into sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| mclr_i | input | 1 | Master reset request |
| sleep_i | input | 1 | Sleep instruction execute strobe |
| wdt_to_i | input | 1 | Watchdog time-out pulse |
| irq_flag_i | input | NUM_SRC | Per-source interrupt flags |
| irq_en_i | input | NUM_SRC | Per-source interrupt enables |
| gie_i | input | 1 | Global interrupt enable |
| osc_rc_i | input | 1 | 1 = RC oscillator, start-up delay skipped |
| clk_en_o | output | 1 | Core clock gate enable |
| wdt_clr_o | output | 1 | Watchdog and prescaler clear |
| pd_o | output | 1 | Power-down status bit |
| to_o | output | 1 | Time-out status bit |
| core_rst_o | output | 1 | Full core reset pulse |
| fetch_o | output | 2 | Resume command: 00 none, 01 in line, 10 vector |

## Verification
The bench builds the block with NUM_SRC=3 and OST_BITS=4, so the crystal start-up wait lasts only 16 cycles. With that setting the bench can sweep every combination of oscillator mode, global enable and wake source, including each interrupt source and the watchdog. For every combination it counts the exact number of clock edges until the clock comes back. Three interrupt sources are also enough to pair each flag with a different source's enable bit, which shows that enables are matched per source. The no-op, same-edge and master-reset orderings are each exercised directly.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_OST   = 2'd2
  } swc_state_e;

  typedef enum logic [1:0] {
    FETCH_NONE   = 2'b00,
    FETCH_INLINE = 2'b01,
    FETCH_VECTOR = 2'b10
  } swc_fetch_e;
endpackage

// File: rtl/swc_pend_detect.sv
module swc_pend_detect #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] flag_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic               pend_o,
  output logic               pend_q_o
);
  logic [NUM_SRC-1:0] hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign hit[g] = flag_i[g] & en_i[g];
  end

  assign pend_o = |hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q_o <= 1'b0;
    else         pend_q_o <= pend_o;
  end
endmodule

// File: rtl/swc_ost_counter.sv
module swc_ost_counter #(
  parameter int OST_BITS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic count_i,
  output logic done_o
);
  localparam logic [OST_BITS-1:0] CntMax = {OST_BITS{1'b1}};

  logic [OST_BITS-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (count_i) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = count_i && (cnt_q == CntMax);
endmodule

// File: rtl/swc_status_bits.sv
module swc_status_bits (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_go_i,
  input  logic wdt_wake_i,
  output logic pd_o,
  output logic to_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_o <= 1'b1;
      to_o <= 1'b1;
    end else if (sleep_go_i) begin
      pd_o <= 1'b0;
      to_o <= 1'b1;
    end else if (wdt_wake_i) begin
      to_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int OST_BITS = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mclr_i,
  input  logic               sleep_i,
  input  logic               wdt_to_i,
  input  logic [NUM_SRC-1:0] irq_flag_i,
  input  logic [NUM_SRC-1:0] irq_en_i,
  input  logic               gie_i,
  input  logic               osc_rc_i,
  output logic               clk_en_o,
  output logic               wdt_clr_o,
  output logic               pd_o,
  output logic               to_o,
  output logic               core_rst_o,
  output logic [1:0]         fetch_o
);
  swc_state_e state_q, state_d;
  swc_fetch_e fetch_q, fetch_d;
  logic pend, pend_q, ost_done, sleep_go, wake, wdt_wake, resume, rst_q;

  swc_pend_detect #(.NUM_SRC(NUM_SRC)) i_pend (
    .clk_i, .rst_ni, .flag_i(irq_flag_i), .en_i(irq_en_i),
    .pend_o(pend), .pend_q_o(pend_q)
  );

  swc_ost_counter #(.OST_BITS(OST_BITS)) i_ost (
    .clk_i, .rst_ni, .clear_i(sleep_go), .count_i(state_q == ST_OST),
    .done_o(ost_done)
  );

  swc_status_bits i_status (
    .clk_i, .rst_ni, .sleep_go_i(sleep_go), .wdt_wake_i(wdt_wake),
    .pd_o, .to_o
  );

  // a request pending in the previous cycle turns sleep into a no-op
  assign sleep_go = (state_q == ST_RUN) && sleep_i && !pend_q && !mclr_i;
  assign wake     = (state_q == ST_SLEEP) && (pend || wdt_to_i) && !mclr_i;
  assign wdt_wake = wake && wdt_to_i;
  assign resume   = (wake && osc_rc_i) || (state_q == ST_OST && ost_done && !mclr_i);

  always_comb begin
    state_d = state_q;
    fetch_d = FETCH_NONE;
    if (mclr_i) begin
      state_d = ST_RUN;
    end else begin
      unique case (state_q)
        ST_RUN:   if (sleep_go) state_d = ST_SLEEP;
        ST_SLEEP: if (wake) state_d = osc_rc_i ? ST_RUN : ST_OST;
        ST_OST:   if (ost_done) state_d = ST_RUN;
        default:  state_d = ST_RUN;
      endcase
      if (resume) fetch_d = gie_i ? FETCH_VECTOR : FETCH_INLINE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      fetch_q <= FETCH_NONE;
      rst_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      fetch_q <= fetch_d;
      rst_q   <= mclr_i;
    end
  end

  assign clk_en_o   = (state_q == ST_RUN);
  assign wdt_clr_o  = sleep_go;
  assign core_rst_o = rst_q;
  assign fetch_o    = fetch_q;

  AST_NOP_KEEPS_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_o && sleep_i && pend_q) |=> (pd_o == $past(pd_o)) && clk_en_o); // R4
  AST_SLEEP_MARKS_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_o && sleep_i && !pend_q && !mclr_i) |=> !pd_o && to_o && !clk_en_o); // R5
  AST_WDT_CLEARS_TO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP && wdt_to_i && !mclr_i) |=> !to_o); // R3
  AST_FETCH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_o != FETCH_NONE) |=> (fetch_o == FETCH_NONE)); // R7
  AST_FETCH_WITH_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_o != FETCH_NONE) |-> clk_en_o); // R7
  AST_RC_NO_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP && wake && osc_rc_i) |=> clk_en_o); // R8
  AST_MCLR_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclr_i |=> clk_en_o && core_rst_o && $stable(pd_o) && $stable(to_o)); // R6
endmodule

// File: tb/test_sleep_wake_ctrl.sv
module test_sleep_wake_ctrl;
  localparam int N = 3;
  localparam int OB = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mclr = 0, sleep = 0, wdt_to = 0, gie = 0, osc_rc = 0;
  logic [N-1:0] flag = '0, en = '0;
  logic clk_en, wdt_clr, pd, to, core_rst;
  logic [1:0] fetch;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sleep_wake_ctrl #(.NUM_SRC(N), .OST_BITS(OB)) i_sleep_wake_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .mclr_i(mclr), .sleep_i(sleep), .wdt_to_i(wdt_to),
    .irq_flag_i(flag), .irq_en_i(en), .gie_i(gie), .osc_rc_i(osc_rc),
    .clk_en_o(clk_en), .wdt_clr_o(wdt_clr), .pd_o(pd), .to_o(to),
    .core_rst_o(core_rst), .fetch_o(fetch)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic go_sleep();
    @(negedge clk); sleep = 1;
    #1 chk("R5 wdt_clr", wdt_clr, 1);
    @(negedge clk); sleep = 0;
    chk("R5 pd", pd, 0); chk("R5 to", to, 1); chk("R5 clk_en", clk_en, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 clk_en", clk_en, 1); chk("R1 pd", pd, 1); chk("R1 to", to, 1);
    chk("R1 fetch", fetch, 0); chk("R1 wdt_clr", wdt_clr, 0); chk("R1 core_rst", core_rst, 0);
    rst_n = 1;

    // R4: pending before sleep -> no-op
    @(negedge clk); flag = 3'b001; en = 3'b001;
    @(negedge clk); sleep = 1;
    #1 chk("R4 wdt_clr", wdt_clr, 0);
    @(negedge clk); sleep = 0;
    chk("R4 clk_en", clk_en, 1); chk("R4 pd", pd, 1);
    flag = '0; en = '0;

    for (int rc = 0; rc < 2; rc++)
      for (int g = 0; g < 2; g++)
        for (int src = 0; src <= N; src++) begin
          int cnt;
          osc_rc = rc[0]; gie = g[0];
          repeat (2) @(negedge clk);
          go_sleep();
          if (src < N) begin
            flag = '0; en = '0;
            flag[src] = 1'b1; en[(src+1)%N] = 1'b1;
            repeat (3) @(negedge clk);
            chk("R2 mismatched enable", clk_en, 0);
            en = '0; en[src] = 1'b1;
          end else begin
            wdt_to = 1;
          end
          cnt = 0;
          do begin
            @(posedge clk); cnt++;
            @(negedge clk); wdt_to = 0;
          end while (!clk_en && cnt < 100);
          chk("R8 wake latency", cnt, 1 + (rc ? 0 : 2**OB));
          chk("R7 fetch", fetch, g ? 2 : 1);
          chk("R3 to", to, (src == N) ? 0 : 1);
          flag = '0; en = '0;
          @(negedge clk);
          chk("R7 fetch drop", fetch, 0);
        end

    // R5: request in the sleep cycle counts as during
    osc_rc = 1; gie = 0;
    repeat (2) @(negedge clk);
    @(negedge clk); sleep = 1; flag = 3'b100; en = 3'b100;
    #1 chk("R5 same-edge wdt_clr", wdt_clr, 1);
    @(negedge clk); sleep = 0;
    chk("R5 same-edge pd", pd, 0); chk("R5 same-edge clk_en", clk_en, 0);
    @(negedge clk);
    chk("R5 same-edge wake", clk_en, 1); chk("R2 wake gie=0", fetch, 1);
    flag = '0; en = '0;

    // R6: master reset while asleep
    repeat (2) @(negedge clk);
    go_sleep();
    mclr = 1;
    @(negedge clk); mclr = 0;
    chk("R6 core_rst", core_rst, 1); chk("R6 clk_en", clk_en, 1);
    chk("R6 pd kept", pd, 0); chk("R6 fetch", fetch, 0);
    @(negedge clk);
    chk("R6 core_rst drop", core_rst, 0);

    // R6: master reset during start-up wait, and over a sleep request
    osc_rc = 0;
    go_sleep();
    wdt_to = 1;
    @(negedge clk); wdt_to = 0;
    repeat (4) @(negedge clk);
    chk("R8 in start-up", clk_en, 0);
    mclr = 1; sleep = 1;
    @(negedge clk); mclr = 0; sleep = 0;
    chk("R6 from start-up", clk_en, 1); chk("R6 to kept", to, 0);
    chk("R6 priority over sleep", pd, 0);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule